// File: doc/BRIEF.md
# Voice Envelope Generator with ADSR and Gain Modes

This block produces the loudness envelope of one synthesizer voice. It reads three envelope control bytes, decodes them into an operating mode, a rate index and a target or fixed level, and then steps an 11-bit envelope level register. A voice engine samples that register once per output sample. A key-on pulse restarts the envelope and a key-off pulse releases it. A sample-rate tick paces all stepping.

Control byte A bit 7 chooses the mode. When it is set, the four-phase mode runs: attack, then decay, then sustain, then release. When it is clear, the gain byte drives the level. The gain byte can hold the level at a fixed value, or it can ramp the level up along a straight or bent line, or down along a straight line or an exponential curve.

Each rate index selects a step period measured in ticks. A per-voice counter counts ticks and steps the level each time the counter expires.

Top module: `envGen`

## Requirements
- R1: After reset, envLevel is 0 and envMode is 3 (release).
- R2: A keyOn pulse without keyOff clears envLevel to 0, restarts the period counter and enters attack phase. In four-phase mode envMode then reads 0. If keyOn and keyOff arrive in the same cycle, keyOff wins and keyOn is ignored. A tick in the same cycle as a key pulse causes no step.
- R3: A keyOff pulse enters release, in either mode, and envMode reads 3. In release, every tick lowers the level by 8, stopping at 0. The control bytes have no effect during release.
- R4: A rate index r from 1 to 31 gives a step period of 2^((31-r) div 4) ticks. Rate index 0 never steps, so the level holds.
- R5: Attack with index a (control byte A bits 3:0) below 15 uses rate 2a+1 and adds 32 per step. When the level reaches 2047, the phase moves to decay (envMode 1).
- R6: Attack index 15 adds 1024 on every tick. The level therefore reaches its maximum of 2047 after two ticks.
- R7: Decay with index d (control byte A bits 6:4) uses rate 2d+16. Each step subtracts ((level-1)>>8)+1. When level bits 10:8 are at or below the sustain level (control byte B bits 7:5), the phase moves to sustain (envMode 2). Sustain applies the same exponential step at rate control byte B bits 4:0. In four-phase mode the gain byte has no effect.
- R8: With control byte A bit 7 clear and gain bit 7 clear, each tick loads the level with gain bits 6:0 times 16. envMode reads 4.
- R9: Gain bits 7:6 = 11 ramp the level up at rate gain bits 4:0, stopping at 2047. With gain bit 5 clear, each step adds 32 (envMode 5). With gain bit 5 set, each step adds 32 below 1536 and 8 at or above it (envMode 6).
- R10: Gain bits 7:6 = 10 ramp the level down at rate gain bits 4:0, stopping at 0. With gain bit 5 clear, each step subtracts 32 (envMode 7). With gain bit 5 set, each step subtracts ((level-1)>>8)+1 (envMode 8).
- R11: In a cycle with no tick and no keyOn, envLevel does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| envAdsr1 | input | 8 | Control byte A: mode select, decay index, attack index |
| envAdsr2 | input | 8 | Control byte B: sustain level, sustain rate index |
| envGain | input | 8 | Gain byte: gain sub-mode and rate or direct level |
| keyOn | input | 1 | One-cycle note start pulse |
| keyOff | input | 1 | One-cycle note release pulse |
| tick | input | 1 | Sample-rate step enable |
| envLevel | output | 11 | Current envelope level, 0 to 2047 |
| envMode | output | 4 | Active mode code: 0 attack, 1 decay, 2 sustain, 3 release, 4 direct, 5 linear rise, 6 bent rise, 7 linear fall, 8 exponential fall |

## Verification
Two pairs of events can land in the same clock cycle. The first is keyOn with keyOff. The second is a key pulse with a tick. The bench drives both key pulses together on a voice that is in release with a non-zero level. The level must stay where it was and the mode must stay release. The bench also raises keyOn and tick in the same cycle. The level must read 0 in attack with no step applied, and a later tick must then add exactly one step.

// File: rtl/envPkg.sv
package envPkg;

  typedef enum logic [1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY   = 2'd1,
    PH_SUSTAIN = 2'd2,
    PH_RELEASE = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LIN_UP,
    OP_FAST_UP,
    OP_BENT_UP,
    OP_LIN_DN,
    OP_EXP_DN,
    OP_REL_DN,
    OP_LOAD
  } op_e;

  typedef enum logic [3:0] {
    MD_ATTACK   = 4'd0,
    MD_DECAY    = 4'd1,
    MD_SUSTAIN  = 4'd2,
    MD_RELEASE  = 4'd3,
    MD_DIRECT   = 4'd4,
    MD_UP_LIN   = 4'd5,
    MD_UP_BENT  = 4'd6,
    MD_DN_LIN   = 4'd7,
    MD_DN_EXP   = 4'd8
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       clear;
    logic       step;
    op_e        op;
    logic [6:0] direct;
  } envStrobe_t;

  // Tick period for a 5-bit rate index; 0 means the index never steps
  function automatic logic [8:0] ratePeriod(input logic [4:0] r);
    logic [4:0] inv;
    inv = 5'd31 - r;
    if (r == 5'd0) return 9'd0;
    return 9'd1 << inv[4:2];
  endfunction

endpackage

// File: rtl/envCtrl.sv
module envCtrl
  import envPkg::*;
#(
  parameter int LVL_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       adsr1,
  input  logic [7:0]       adsr2,
  input  logic [7:0]       gain,
  input  logic             keyOn,
  input  logic             keyOff,
  input  logic             tick,
  input  logic [LVL_W-1:0] level,
  output envStrobe_t       strobe,
  output logic [3:0]       mode
);

  localparam logic [LVL_W-1:0] MAXV = {LVL_W{1'b1}};

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [4:0]       rate;
  op_e              op;
  logic [CNT_W:0]   period;
  logic [CNT_W:0]   cntInc;
  logic             expire;
  logic             keyEvt;
  logic             adsrMode;

  assign adsrMode = adsr1[7];
  assign keyEvt   = keyOn | keyOff;

  // Rate index and step operation for the active mode and phase
  always_comb begin
    rate = 5'd0;
    op   = OP_NONE;
    if (phase == PH_RELEASE) begin
      rate = 5'd31;
      op   = OP_REL_DN;
    end else if (adsrMode) begin
      case (phase)
        PH_ATTACK: begin
          if (&adsr1[3:0]) begin
            rate = 5'd31;
            op   = OP_FAST_UP;
          end else begin
            rate = {adsr1[3:0], 1'b1};
            op   = OP_LIN_UP;
          end
        end
        PH_DECAY: begin
          rate = {1'b1, adsr1[6:4], 1'b0};
          op   = OP_EXP_DN;
        end
        PH_SUSTAIN: begin
          rate = adsr2[4:0];
          op   = OP_EXP_DN;
        end
        default: begin
          rate = 5'd0;
          op   = OP_NONE;
        end
      endcase
    end else if (!gain[7]) begin
      rate = 5'd31;
      op   = OP_LOAD;
    end else begin
      rate = gain[4:0];
      if (gain[6]) op = gain[5] ? OP_BENT_UP : OP_LIN_UP;
      else         op = gain[5] ? OP_EXP_DN  : OP_LIN_DN;
    end
  end

  assign period = (CNT_W+1)'(ratePeriod(rate));
  assign cntInc = {1'b0, cnt} + 1'b1;
  assign expire = (rate != 5'd0) && (cntInc >= period);

  assign strobe.clear  = keyOn & ~keyOff;
  assign strobe.step   = tick & ~keyEvt & expire;
  assign strobe.op     = op;
  assign strobe.direct = gain[6:0];

  // Tick counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (keyOn && !keyOff) begin
      cnt <= '0;
    end else if (tick && !keyEvt && rate != 5'd0) begin
      cnt <= expire ? '0 : cntInc[CNT_W-1:0];
    end
  end

  // Phase sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_RELEASE;
    end else if (keyOff) begin
      phase <= PH_RELEASE;
    end else if (keyOn) begin
      phase <= PH_ATTACK;
    end else if (adsrMode) begin
      if (phase == PH_ATTACK && level == MAXV)
        phase <= PH_DECAY;
      else if (phase == PH_DECAY && level[LVL_W-1 -: 3] <= adsr2[7:5])
        phase <= PH_SUSTAIN;
    end
  end

  // Externally visible mode code
  always_comb begin
    if (phase == PH_RELEASE)      mode = MD_RELEASE;
    else if (adsrMode)            mode = {2'b00, phase};
    else if (!gain[7])            mode = MD_DIRECT;
    else if (gain[6])             mode = gain[5] ? MD_UP_BENT : MD_UP_LIN;
    else                          mode = gain[5] ? MD_DN_EXP  : MD_DN_LIN;
  end

endmodule

// File: rtl/envData.sv
module envData
  import envPkg::*;
#(
  parameter int LVL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  envStrobe_t       strobe,
  output logic [LVL_W-1:0] level
);

  localparam int          SUM_W = LVL_W + 1;
  localparam logic [SUM_W-1:0] MAXV  = SUM_W'((1 << LVL_W) - 1);
  localparam logic [SUM_W-1:0] LIN   = SUM_W'(1 << (LVL_W - 6));
  localparam logic [SUM_W-1:0] FINE  = SUM_W'(1 << (LVL_W - 8));
  localparam logic [SUM_W-1:0] FAST  = SUM_W'(1 << (LVL_W - 1));
  localparam logic [SUM_W-1:0] KNEE  = SUM_W'(3 << (LVL_W - 2));
  localparam int          EXP_SH = LVL_W - 3;

  logic [SUM_W-1:0] cur;
  logic [SUM_W-1:0] upAmt;
  logic [SUM_W-1:0] dnAmt;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] expAmt;
  logic             isUp;
  logic [LVL_W-1:0] nextLevel;

  assign cur    = {1'b0, level};
  assign expAmt = (level == '0) ? '0 : ((cur - 1'b1) >> EXP_SH) + 1'b1;

  always_comb begin
    upAmt = '0;
    dnAmt = '0;
    isUp  = 1'b0;
    case (strobe.op)
      OP_LIN_UP:  begin upAmt = LIN;  isUp = 1'b1; end
      OP_FAST_UP: begin upAmt = FAST; isUp = 1'b1; end
      OP_BENT_UP: begin upAmt = (cur < KNEE) ? LIN : FINE; isUp = 1'b1; end
      OP_LIN_DN:  dnAmt = LIN;
      OP_EXP_DN:  dnAmt = expAmt;
      OP_REL_DN:  dnAmt = FINE;
      default:    ;
    endcase
  end

  assign sum = cur + upAmt;

  always_comb begin
    if (strobe.op == OP_LOAD)
      nextLevel = {strobe.direct, {(LVL_W-7){1'b0}}};
    else if (isUp)
      nextLevel = (sum > MAXV) ? MAXV[LVL_W-1:0] : sum[LVL_W-1:0];
    else if (cur < dnAmt)
      nextLevel = '0;
    else
      nextLevel = level - dnAmt[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            level <= '0;
    else if (strobe.clear) level <= '0;
    else if (strobe.step)  level <= nextLevel;
  end

endmodule

// File: rtl/envGen.sv
module envGen
  import envPkg::*;
#(
  parameter int LVL_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       envAdsr1,
  input  logic [7:0]       envAdsr2,
  input  logic [7:0]       envGain,
  input  logic             keyOn,
  input  logic             keyOff,
  input  logic             tick,
  output logic [LVL_W-1:0] envLevel,
  output logic [3:0]       envMode
);

  envStrobe_t strobe;

  envCtrl #(.LVL_W(LVL_W), .CNT_W(CNT_W)) uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .adsr1  (envAdsr1),
    .adsr2  (envAdsr2),
    .gain   (envGain),
    .keyOn  (keyOn),
    .keyOff (keyOff),
    .tick   (tick),
    .level  (envLevel),
    .strobe (strobe),
    .mode   (envMode)
  );

  envData #(.LVL_W(LVL_W)) uData (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .level  (envLevel)
  );

endmodule

// File: rtl/envGenChk.sv
module envGenChk #(
  parameter int LVL_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       envAdsr1,
  input logic [7:0]       envGain,
  input logic             keyOn,
  input logic             keyOff,
  input logic             tick,
  input logic [LVL_W-1:0] envLevel,
  input logic [3:0]       envMode
);

  logic [LVL_W-1:0] directVal;
  assign directVal = {envGain[6:0], {(LVL_W-7){1'b0}}};

  AST_KEYON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    keyOn && !keyOff |=> envLevel == '0); // R2

  AST_KEYOFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    keyOff |=> envMode == 4'd3); // R3

  AST_RELEASE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    envMode == 4'd3 && !keyOn |=> envLevel <= $past(envLevel)); // R3

  AST_RATE_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !keyOn && !keyOff && !envAdsr1[7] && envGain[7] &&
    envGain[4:0] == 5'd0 && envMode != 4'd3 |=> $stable(envLevel)); // R4

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !keyOn && !keyOff && !envAdsr1[7] && !envGain[7] &&
    envMode != 4'd3 |=> envLevel == $past(directVal)); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !keyOn |=> $stable(envLevel)); // R11

endmodule

bind envGen envGenChk #(.LVL_W(LVL_W)) uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .envAdsr1 (envAdsr1),
  .envGain  (envGain),
  .keyOn    (keyOn),
  .keyOff   (keyOff),
  .tick     (tick),
  .envLevel (envLevel),
  .envMode  (envMode)
);

// File: tb/tb_envGen.sv
module tb_envGen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  envAdsr1 = 8'h00;
  logic [7:0]  envAdsr2 = 8'h00;
  logic [7:0]  envGain = 8'h00;
  logic        keyOn = 1'b0;
  logic        keyOff = 1'b0;
  logic        tick = 1'b0;
  logic [10:0] envLevel;
  logic [3:0]  envMode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  envGen dut (
    .clk(clk), .rst_n(rst_n), .envAdsr1(envAdsr1), .envAdsr2(envAdsr2),
    .envGain(envGain), .keyOn(keyOn), .keyOff(keyOff), .tick(tick),
    .envLevel(envLevel), .envMode(envMode)
  );

  // act: 0 none, 1 keyOn pulse, 2 keyOff pulse, applied before the ticks
  typedef struct packed {
    logic [7:0]  a1;
    logic [7:0]  a2;
    logic [7:0]  g;
    logic [1:0]  act;
    logic [7:0]  nt;
    logic [10:0] lvl;
    logic [3:0]  md;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 8'h45, 2'd1, 8'd1,  11'h450, 4'd4}, // R8 direct
    '{8'h00, 8'h00, 8'hDF, 2'd0, 8'd3,  11'h4B0, 4'd5}, // R9 linear rise
    '{8'h00, 8'h00, 8'hFF, 2'd0, 8'd12, 11'h618, 4'd6}, // R9 bent rise
    '{8'h00, 8'h00, 8'h9F, 2'd0, 8'd4,  11'h598, 4'd7}, // R10 linear fall
    '{8'h00, 8'h00, 8'hBF, 2'd0, 8'd2,  11'h58C, 4'd8}, // R10 exp fall
    '{8'h00, 8'h00, 8'hA0, 2'd0, 8'd5,  11'h58C, 4'd8}, // R4 index 0
    '{8'h00, 8'h00, 8'h9B, 2'd0, 8'd5,  11'h54C, 4'd7}, // R4 period 2
    '{8'h8E, 8'hE0, 8'h45, 2'd1, 8'd4,  11'h080, 4'd0}, // R5 attack
    '{8'h8F, 8'hE0, 8'h00, 2'd1, 8'd2,  11'h7FF, 4'd2}, // R6 fast attack
    '{8'h8F, 8'hE0, 8'hDF, 2'd0, 8'd3,  11'h7FF, 4'd2}, // R7 sustain rate 0
    '{8'hFF, 8'hA0, 8'h00, 2'd1, 8'd2,  11'h7FF, 4'd1}, // R7 decay entry
    '{8'hFF, 8'hA0, 8'h00, 2'd0, 8'd3,  11'h7E7, 4'd1}, // R7 decay steps
    '{8'hFF, 8'hA0, 8'h00, 2'd2, 8'd4,  11'h7C7, 4'd3}, // R3 release
    '{8'h00, 8'h00, 8'h10, 2'd0, 8'd1,  11'h7BF, 4'd3}  // R3 gain ignored
  };

  task automatic check(input string req, input logic [10:0] actL, input logic [10:0] expL,
                       input logic [3:0] actM, input logic [3:0] expM);
    checks++;
    if (actL !== expL || actM !== expM) begin
      fails++;
      $display("FAIL %s: level=%h mode=%0d expected level=%h mode=%0d",
               req, actL, actM, expL, expM);
    end
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse(input bit on, input bit off);
    @(negedge clk); keyOn = on; keyOff = off;
    @(negedge clk); keyOn = 1'b0; keyOff = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", envLevel, 11'h000, envMode, 4'd3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release of reset", envLevel, 11'h000, envMode, 4'd3);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      envAdsr1 = VEC[v].a1; envAdsr2 = VEC[v].a2; envGain = VEC[v].g;
      if (VEC[v].act == 2'd1) pulse(1'b1, 1'b0);
      else if (VEC[v].act == 2'd2) pulse(1'b0, 1'b1);
      doTicks(int'(VEC[v].nt));
      settle();
      check($sformatf("vector %0d", v), envLevel, VEC[v].lvl, envMode, VEC[v].md);
    end

    // R11: no tick, no key: level holds over many cycles
    repeat (10) @(negedge clk);
    check("R11 idle hold", envLevel, 11'h7BF, envMode, 4'd3);

    // R2: keyOn with keyOff together -> keyOff wins, level kept
    envAdsr1 = 8'h8E; envAdsr2 = 8'hE0;
    pulse(1'b1, 1'b1);
    settle();
    check("R2 keyOn+keyOff same cycle", envLevel, 11'h7BF, envMode, 4'd3);

    // R2: keyOn with tick in same cycle -> cleared, no step
    @(negedge clk); keyOn = 1'b1; tick = 1'b1;
    @(negedge clk); keyOn = 1'b0; tick = 1'b0;
    settle();
    check("R2 keyOn+tick same cycle", envLevel, 11'h000, envMode, 4'd0);
    doTicks(1);
    settle();
    check("R2 one step after keyOn", envLevel, 11'h020, envMode, 4'd0);

    // R3: release stops at zero
    pulse(1'b0, 1'b1);
    doTicks(5);
    settle();
    check("R3 release floor", envLevel, 11'h000, envMode, 4'd3);

    // R4: rate index 1 -> period 128 ticks
    envAdsr1 = 8'h00; envGain = 8'hC1;
    pulse(1'b1, 1'b0);
    doTicks(127);
    settle();
    check("R4 period 128 not yet", envLevel, 11'h000, envMode, 4'd5);
    doTicks(1);
    settle();
    check("R4 period 128 step", envLevel, 11'h020, envMode, 4'd5);

    // R5: attack reaching max moves to decay (decay idx 0, sustain lvl 0)
    envAdsr1 = 8'h8E; envAdsr2 = 8'h00;
    pulse(1'b1, 1'b0);
    doTicks(64);
    settle();
    check("R5 attack to decay", envLevel, 11'h7FF, envMode, 4'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule